// File: doc/BRIEF.md
# Flash Control/Status Register with Boot-Block Remap

This block is a single byte-wide control/status register that governs a parallel flash bank. It samples three board-level inputs: the boot-block selection switch, the hardware write-protect switch, and the flash ready lines of every device in the bank. Each device ready line is high when that device is ready. The lines are combined as a wired connection, so the bank is ready only when every device is ready. Software controls two bits: a software write-protect bit and a map-select override.

The block turns these inputs into two signals for the flash path. The first is a gated write strobe. A write strobe reaches the flash only when both protection sources are clear. An attempt made while protected is dropped, and a sticky violation flag records it. The second is a boot-block remap flag. When this flag is high, the address bit that separates the two boot blocks is inverted, so that block B answers at the top of the flash window. Setting the map-select bit forces block A to the top, whatever the switch says.

Top module: `flash_csr_ctrl`

## Requirements
- R1: After reset, a read of offset 3 returns the software write-protect bit (bit 3) as 1, the map-select bit (bit 4) as 0 and bits 7..5 as 0. The violation flag reads 0 and the read data register reads 0.
- R2: Bit 0 of offset 3 reads 1 only when every device ready input is 1, and reads 0 when any one of them is 0.
- R3: Bit 1 shows the boot-block switch and bit 2 shows the hardware write-protect switch, both through a two-flop synchronizer. A change at an input reaches the synchronized value, and the boot remap flag, on the second rising edge after the change. Bits 0..2 are read-only, so writing them has no effect.
- R4: At offset 3, writes update bit 3 (software write protect) and bit 4 (map select), and a later read returns them. Bits 7..5 always read 0 and ignore written ones.
- R5: The flash write output equals the flash write strobe in the same cycle when the software bit and the synchronized hardware switch are both 0. Otherwise it is 0.
- R6: A write strobe that arrives while protected sets the violation flag at the next rising edge. The flag then stays 1 until reset.
- R7: The boot remap output is 1 exactly when the synchronized boot switch is 1 and map select is 0.
- R8: Read data is registered and appears after the rising edge that samples the read. Reads of offsets 0..2 return 0, and writes to those offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_cs | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_off | input | 2 | Register byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| dev_rdy | input | NUM_DEV (2) | Per-device ready lines, 1 = ready |
| sw_boot_b | input | 1 | Boot-block switch, 1 = block B at top |
| sw_hw_wp | input | 1 | Hardware write-protect switch, 1 = protected |
| flash_we_req | input | 1 | Flash write strobe from the flash controller |
| flash_we_out | output | 1 | Gated write strobe to the flash |
| boot_remap | output | 1 | Inverts the boot-block address bit when 1 |
| wr_violation | output | 1 | Sticky flag for a dropped protected write |

## Verification
Read data is due one rising edge after the cycle in which the read strobe is sampled. The monitor samples every read 1 ns after that edge and compares it with the value queued by the driver. Switch and ready changes need two edges to pass the synchronizer, so the bench waits at least three cycles before reading them. For the lag case, it checks the remap flag just after the first edge, where the old value is expected, and just after the second edge, where the new value is expected. The gated write strobe is combinational and is checked in the same cycle as the strobe. The violation flag is checked after the following edge.

// File: rtl/flash_csr_pkg.sv
package flash_csr_pkg;
  localparam int DATA_W   = 8;
  localparam int BIT_RDY  = 0;
  localparam int BIT_BOOT = 1;
  localparam int BIT_HWWP = 2;
  localparam int BIT_SWWP = 3;
  localparam int BIT_MAP  = 4;

  function automatic logic wr_allowed(input logic sw_wp, input logic hw_wp);
    return !sw_wp && !hw_wp;
  endfunction

  function automatic logic remap_sel(input logic boot_b, input logic map_sel);
    return boot_b && !map_sel;
  endfunction

  function automatic logic [DATA_W-1:0] pack_status(input logic rdy, input logic boot_b,
                                                    input logic hw_wp, input logic sw_wp,
                                                    input logic map_sel);
    logic [DATA_W-1:0] v;
    v = '0;
    v[BIT_RDY]  = rdy;
    v[BIT_BOOT] = boot_b;
    v[BIT_HWWP] = hw_wp;
    v[BIT_SWWP] = sw_wp;
    v[BIT_MAP]  = map_sel;
    return v;
  endfunction
endpackage

// File: rtl/flash_csr_sync.sv
module flash_csr_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= d_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '0;
      else        chain[s] <= chain[s-1];
    end
  end

  assign d_out = chain[STAGES-1];
endmodule

// File: rtl/flash_csr_regs.sv
module flash_csr_regs
  import flash_csr_pkg::*;
#(
  parameter int OFF_W   = 2,
  parameter int CSR_OFF = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_cs,
  input  logic              bus_we,
  input  logic [OFF_W-1:0]  bus_off,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              rdy_s,
  input  logic              boot_s,
  input  logic              hwwp_s,
  output logic              sw_wp,
  output logic              map_sel
);
  logic hit, csr_wr, csr_rd, other_rd;
  assign hit      = bus_cs && (bus_off == OFF_W'(CSR_OFF));
  assign csr_wr   = hit && bus_we;
  assign csr_rd   = hit && !bus_we;
  assign other_rd = bus_cs && !bus_we && !hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_wp   <= 1'b1;
      map_sel <= 1'b0;
    end else if (csr_wr) begin
      sw_wp   <= bus_wdata[BIT_SWWP];
      map_sel <= bus_wdata[BIT_MAP];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        bus_rdata <= '0;
    else if (csr_rd)   bus_rdata <= pack_status(rdy_s, boot_s, hwwp_s, sw_wp, map_sel);
    else if (other_rd) bus_rdata <= '0;
  end

  assert_rsvd_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DATA_W-1:BIT_MAP+1] == '0);
  assert_map_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    csr_wr |=> (map_sel == $past(bus_wdata[BIT_MAP])) && (sw_wp == $past(bus_wdata[BIT_SWWP])));
  assert_other_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    other_rd |=> bus_rdata == '0);
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_wr |=> $stable(map_sel) && $stable(sw_wp));
endmodule

// File: rtl/flash_csr_gate.sv
module flash_csr_gate
  import flash_csr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic flash_we_req,
  input  logic sw_wp,
  input  logic hwwp_s,
  input  logic boot_s,
  input  logic map_sel,
  output logic flash_we_out,
  output logic boot_remap,
  output logic wr_violation
);
  logic allow, drop_evt;
  assign allow        = wr_allowed(sw_wp, hwwp_s);
  assign flash_we_out = flash_we_req && allow;
  assign drop_evt     = flash_we_req && !allow;
  assign boot_remap   = remap_sel(boot_s, map_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        wr_violation <= 1'b0;
    else if (drop_evt) wr_violation <= 1'b1;
  end

  assert_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wp || hwwp_s) |-> !flash_we_out);
  assert_sets_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flash_we_req && !flash_we_out) |=> wr_violation);
  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_violation |=> wr_violation);
  assert_override_R7: assert property (@(posedge clk) disable iff (!rst_n)
    map_sel |-> !boot_remap);
endmodule

// File: rtl/flash_csr_ctrl.sv
module flash_csr_ctrl
  import flash_csr_pkg::*;
#(
  parameter int NUM_DEV     = 2,
  parameter int OFF_W       = 2,
  parameter int CSR_OFF     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_cs,
  input  logic               bus_we,
  input  logic [OFF_W-1:0]   bus_off,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_DEV-1:0] dev_rdy,
  input  logic               sw_boot_b,
  input  logic               sw_hw_wp,
  input  logic               flash_we_req,
  output logic               flash_we_out,
  output logic               boot_remap,
  output logic               wr_violation
);
  localparam int SYNC_W = 3;
  logic             bank_rdy;
  logic [SYNC_W-1:0] raw_in, syn_out;
  logic rdy_s, boot_s, hwwp_s, sw_wp, map_sel;

  assign bank_rdy = &dev_rdy;
  assign raw_in   = {sw_hw_wp, sw_boot_b, bank_rdy};

  flash_csr_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(raw_in), .d_out(syn_out));

  assign rdy_s  = syn_out[0];
  assign boot_s = syn_out[1];
  assign hwwp_s = syn_out[2];

  flash_csr_regs #(.OFF_W(OFF_W), .CSR_OFF(CSR_OFF)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_we(bus_we), .bus_off(bus_off),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rdy_s(rdy_s), .boot_s(boot_s),
    .hwwp_s(hwwp_s), .sw_wp(sw_wp), .map_sel(map_sel));

  flash_csr_gate u_gate (
    .clk(clk), .rst_n(rst_n), .flash_we_req(flash_we_req), .sw_wp(sw_wp),
    .hwwp_s(hwwp_s), .boot_s(boot_s), .map_sel(map_sel), .flash_we_out(flash_we_out),
    .boot_remap(boot_remap), .wr_violation(wr_violation));

  assert_reset_prot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !flash_we_out);
endmodule

// File: tb/sim_flash_csr_ctrl.sv
module sim_flash_csr_ctrl;
  logic clk = 0, rst_n = 0;
  logic bus_cs = 0, bus_we = 0;
  logic [1:0] bus_off = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic [1:0] dev_rdy = 2'b11;
  logic sw_boot_b = 0, sw_hw_wp = 0, flash_we_req = 0;
  logic flash_we_out, boot_remap, wr_violation;
  int checks = 0, errors = 0;
  logic m_sw = 1, m_map = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  bit done = 0;

  always #2 clk = ~clk;

  flash_csr_ctrl u0 (.clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_we(bus_we),
    .bus_off(bus_off), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dev_rdy(dev_rdy),
    .sw_boot_b(sw_boot_b), .sw_hw_wp(sw_hw_wp), .flash_we_req(flash_we_req),
    .flash_we_out(flash_we_out), .boot_remap(boot_remap), .wr_violation(wr_violation));

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] model_csr();
    logic [7:0] v;
    v = 8'h00;
    v[0] = &dev_rdy;
    v[1] = sw_boot_b;
    v[2] = sw_hw_wp;
    v[3] = m_sw;
    v[4] = m_map;
    return v;
  endfunction

  task automatic rd(input logic [1:0] o, input string tag);
    @(negedge clk);
    bus_cs = 1; bus_we = 0; bus_off = o;
    exp_q.push_back(o == 2'd3 ? model_csr() : 8'h00);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_cs = 0;
  endtask

  task automatic wr(input logic [1:0] o, input logic [7:0] d);
    @(negedge clk);
    bus_cs = 1; bus_we = 1; bus_off = o; bus_wdata = d;
    @(negedge clk);
    bus_cs = 0; bus_we = 0;
    if (o == 2'd3) begin m_sw = d[3]; m_map = d[4]; end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin : monitor
    forever begin
      logic take;
      @(posedge clk);
      take = bus_cs && !bus_we;
      #1;
      if (take && exp_q.size() > 0) begin
        string t;
        t = tag_q.pop_front();
        check(t, bus_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin : watchdog
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin : stim
    #1;
    check("R1 rdata in reset", bus_rdata, 8'h00);
    repeat (3) @(negedge clk);
    rst_n = 1;
    settle();
    check("R1 violation after reset", {7'b0, wr_violation}, 8'h00);
    rd(2'd3, "R1 reset value");
    // R5/R6: protected write dropped
    @(negedge clk); flash_we_req = 1; #0.5;
    check("R5 dropped while sw protect", {7'b0, flash_we_out}, 8'h00);
    @(negedge clk); flash_we_req = 0;
    check("R6 violation set", {7'b0, wr_violation}, 8'h01);
    // R4: read/write bits and reserved
    wr(2'd3, 8'hFF);
    rd(2'd3, "R4 write FF");
    wr(2'd3, 8'hE0);
    rd(2'd3, "R4 reserved ignored");
    wr(2'd3, 8'h07);
    rd(2'd3, "R3 read-only bits not written");
    // R5: allowed write
    @(negedge clk); flash_we_req = 1; #0.5;
    check("R5 passes when clear", {7'b0, flash_we_out}, 8'h01);
    @(negedge clk); flash_we_req = 0; #0.5;
    check("R5 follows strobe low", {7'b0, flash_we_out}, 8'h00);
    // hardware protect
    sw_hw_wp = 1; settle();
    rd(2'd3, "R3 hw wp bit");
    @(negedge clk); flash_we_req = 1; #0.5;
    check("R5 dropped while hw protect", {7'b0, flash_we_out}, 8'h00);
    @(negedge clk); flash_we_req = 0;
    sw_hw_wp = 0; settle();
    // R2: ready combination
    dev_rdy = 2'b10; settle(); rd(2'd3, "R2 device0 busy");
    dev_rdy = 2'b01; settle(); rd(2'd3, "R2 device1 busy");
    dev_rdy = 2'b00; settle(); rd(2'd3, "R2 both busy");
    dev_rdy = 2'b11; settle(); rd(2'd3, "R2 all ready");
    // R3/R7: synchronizer lag on remap
    @(negedge clk); sw_boot_b = 1;
    @(posedge clk); #1;
    check("R3 remap after first edge", {7'b0, boot_remap}, 8'h00);
    @(posedge clk); #1;
    check("R3 remap after second edge", {7'b0, boot_remap}, 8'h01);
    settle();
    rd(2'd3, "R3 boot switch bit");
    wr(2'd3, 8'h10); #0.5;
    check("R7 map select forces block A", {7'b0, boot_remap}, 8'h00);
    wr(2'd3, 8'h00); #0.5;
    check("R7 remap back with map clear", {7'b0, boot_remap}, 8'h01);
    // R8: other offsets
    rd(2'd0, "R8 offset 0 reads 0");
    rd(2'd1, "R8 offset 1 reads 0");
    rd(2'd2, "R8 offset 2 reads 0");
    wr(2'd2, 8'h18);
    rd(2'd3, "R8 write to offset 2 ignored");
    check("R6 violation sticky", {7'b0, wr_violation}, 8'h01);
    repeat (4) @(negedge clk);
    check("R8 all reads seen", 8'(exp_q.size()), 8'h00);
    done = 1;
    finish_run();
  end
endmodule